// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire stereo PCM stream into parallel samples. The three wires are a bit clock, a word-select (LR) clock and a serial data line. It runs in a master-clock domain at 256 times the sample rate. The bit clock and word-select inputs change in step with that master clock, so the block samples them directly and finds their edges by comparing each with its value one cycle earlier.

A 3-bit format code chooses one of three framings: I2S, MSB-justified or LSB-justified. It also chooses a 16-bit or an 18-bit word. Every received word comes out as an 18-bit value. A 16-bit word sits in the upper bits and the two low bits are zero.

Each left/right pair is presented on an output stream. The stream has a valid signal and a ready signal (out_valid/out_ready). A pair stays on the outputs, unchanged, while out_valid is high and out_ready is low. A pair is accepted at a clock edge where both are high. The audio source cannot be paused, so back-pressure never stalls reception. If a new pair completes before the consumer has accepted the previous one, the new pair replaces the old one and out_valid stays high.

Top module: `audio_serial_rx`

## Requirements
- R1: The data line is sampled into the receiver at each master-clock cycle in which the bit clock is first seen high after being low. The MSB of each word arrives first.
- R2: In I2S framing (code 0 = 16-bit, code 1 = 18-bit), the word's MSB is on the second bit-clock rise after a word-select transition. The word completed at a word-select rising edge is the left channel, and the word completed at a falling edge is the right channel.
- R3: In MSB-justified framing (code 2 = 16-bit, code 3 = 18-bit), the word's MSB is on the first bit-clock rise after a word-select transition. The word completed at a rising edge is the right channel, and the word completed at a falling edge is the left channel.
- R4: In LSB-justified framing (code 4 = 16-bit, code 5 = 18-bit), the word is the last N bits received before the word-select edge. Rising and falling edges map to channels as in R3.
- R5: Format codes 6 and 7 behave exactly as code 0 (I2S, 16-bit).
- R6: A 16-bit word is presented as bits 17..2 of the output, with bits 1..0 zero.
- R7: Bits received outside the word's window in the slot (I2S or MSB-justified padding) do not affect the output.
- R8: A pair completes at each word-select falling edge. out_valid and the pair's data are updated at the first master-clock edge after the cycle in which that falling edge is sampled.
- R9: While out_valid is high and out_ready is low, out_valid, out_left and out_right hold their values. After a cycle with out_valid and out_ready both high, out_valid is low on the next cycle, unless a new pair completes in that cycle.
- R10: A pair that completes while the previous pair is still unaccepted replaces it, and out_valid stays high.
- R11: While rst_n is low, out_valid, out_left and out_right are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck | input | 1 | Serial bit clock, synchronous to clk |
| lrck | input | 1 | Word-select clock, synchronous to clk, changes while bck is low |
| din | input | 1 | Serial audio data |
| fmt | input | 3 | Format code (see R2 to R5) |
| out_ready | input | 1 | Consumer accepts the presented pair |
| out_valid | output | 1 | A received pair is presented |
| out_left | output | 18 | Left-channel word, MSB-aligned |
| out_right | output | 18 | Right-channel word, MSB-aligned |

## Verification
A pair is due one master-clock edge after the cycle in which the word-select falling edge is sampled. The bench drives every input on the falling edge of clk and waits four falling edges after the word-select drop before it samples out_valid and both words. out_ready is held low during this wait, so the result cannot change before it is sampled. An acceptance clears out_valid at the next rising edge, so the cleared state is checked one falling edge after out_ready is raised. The hold and overwrite checks each span whole frames of 256 master-clock cycles.

// File: rtl/aser_pkg.sv
package aser_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    FRM_I2S = 2'd0,
    FRM_MSB = 2'd1,
    FRM_LSB = 2'd2
  } frame_e;

  typedef struct packed {
    frame_e frame;
    logic   long_w;
  } fmt_t;

  // Codes: 0/1 I2S, 2/3 MSB-justified, 4/5 LSB-justified; odd = 18-bit.
  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    case (code)
      3'd1:    f = '{frame: FRM_I2S, long_w: 1'b1};
      3'd2:    f = '{frame: FRM_MSB, long_w: 1'b0};
      3'd3:    f = '{frame: FRM_MSB, long_w: 1'b1};
      3'd4:    f = '{frame: FRM_LSB, long_w: 1'b0};
      3'd5:    f = '{frame: FRM_LSB, long_w: 1'b1};
      default: f = '{frame: FRM_I2S, long_w: 1'b0};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/aser_edge_det.sv
module aser_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic bck,
  input  logic lrck,
  output logic bck_rise,
  output logic lr_rise,
  output logic lr_fall
);
  timeunit 1ns;
  timeprecision 1ps;

  logic bck_q;
  logic lrck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q  <= 1'b0;
      lrck_q <= 1'b0;
    end else begin
      bck_q  <= bck;
      lrck_q <= lrck;
    end
  end

  assign bck_rise = bck & ~bck_q;
  assign lr_rise  = lrck & ~lrck_q;
  assign lr_fall  = ~lrck & lrck_q;
endmodule

// File: rtl/aser_shifter.sv
module aser_shifter
  import aser_pkg::*;
#(
  parameter int MAX_W = 18,
  parameter int MIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bck_rise,
  input  logic             lrck_edge,
  input  logic             din,
  input  fmt_t             fmt,
  output logic [MAX_W-1:0] word
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = $clog2(MAX_W + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int PAD_W = MAX_W - MIN_W;

  logic [MAX_W-1:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] first_idx;
  logic [CNT_W-1:0] wlen;
  logic             take;

  // Position of the MSB in the slot and the word length in bits
  assign first_idx = (fmt.frame == FRM_I2S) ? CNT_W'(1) : CNT_W'(0);
  assign wlen      = fmt.long_w ? CNT_W'(MAX_W) : CNT_W'(MIN_W);

  // LSB-justified keeps the most recent bits; the other framings take a fixed window
  assign take = (fmt.frame == FRM_LSB) ||
                ((cnt >= first_idx) && (cnt < first_idx + wlen));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (lrck_edge) begin
      cnt <= '0;
    end else if (bck_rise) begin
      if (take) shreg <= {shreg[MAX_W-2:0], din};
      if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
    end
  end

  // Word extraction, MSB-aligned, short words zero-filled below
  generate
    if (PAD_W > 0) begin : g_pad
      assign word = fmt.long_w ? shreg : {shreg[MIN_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign word = shreg;
    end
  endgenerate

  // R7: the bit count restarts at every word-select transition
  a_r7_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    lrck_edge |=> (cnt == '0));

  // R2/R3: no shifting happens in the cycle a word-select edge is taken
  a_r3_no_shift_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    lrck_edge |=> $stable(shreg));
endmodule

// File: rtl/aser_pair_out.sv
module aser_pair_out
  import aser_pkg::*;
#(
  parameter int MAX_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lr_rise,
  input  logic             lr_fall,
  input  frame_e           frame,
  input  logic [MAX_W-1:0] word,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [MAX_W-1:0] out_left,
  output logic [MAX_W-1:0] out_right
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [MAX_W-1:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q   <= '0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      if (lr_rise) first_q <= word;
      if (lr_fall) begin
        if (frame == FRM_I2S) begin
          out_left  <= first_q;
          out_right <= word;
        end else begin
          out_right <= first_q;
          out_left  <= word;
        end
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9: a pending pair holds until accepted
  a_r9_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !lr_fall) |=>
      (out_valid && $stable(out_left) && $stable(out_right)));

  // R9: acceptance empties the output
  a_r9_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !lr_fall) |=> !out_valid);

  // R8: valid only rises after a completed frame
  a_r8_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(lr_fall));

  // R10: a completed frame always leaves a pair presented
  a_r10_overwrite_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lr_fall |=> out_valid);
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import aser_pkg::*;
#(
  parameter int MAX_W = 18,
  parameter int MIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bck,
  input  logic             lrck,
  input  logic             din,
  input  logic [2:0]       fmt,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [MAX_W-1:0] out_left,
  output logic [MAX_W-1:0] out_right
);
  timeunit 1ns;
  timeprecision 1ps;

  logic             bck_rise;
  logic             lr_rise;
  logic             lr_fall;
  logic [MAX_W-1:0] word;
  fmt_t             fmt_d;

  assign fmt_d = decode_fmt(fmt);

  aser_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bck      (bck),
    .lrck     (lrck),
    .bck_rise (bck_rise),
    .lr_rise  (lr_rise),
    .lr_fall  (lr_fall)
  );

  aser_shifter #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bck_rise  (bck_rise),
    .lrck_edge (lr_rise | lr_fall),
    .din       (din),
    .fmt       (fmt_d),
    .word      (word)
  );

  aser_pair_out #(.MAX_W(MAX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .lr_rise   (lr_rise),
    .lr_fall   (lr_fall),
    .frame     (fmt_d.frame),
    .word      (word),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
  );

  // R1: word-select never moves in a bit-clock rising cycle
  a_r1_lr_not_on_bck_rise: assert property (@(posedge clk) disable iff (!rst_n)
    bck_rise |-> !(lr_rise || lr_fall));
endmodule

// File: tb/audio_serial_rx_bench.sv
module audio_serial_rx_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bck = 1'b0;
  logic        lrck = 1'b0;
  logic        din = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [17:0] out_left;
  logic [17:0] out_right;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  audio_serial_rx u_audio_serial_rx (
    .clk(clk), .rst_n(rst_n), .bck(bck), .lrck(lrck), .din(din), .fmt(fmt),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  // {fmt, first-slot word, second-slot word, expected left, expected right}
  localparam logic [74:0] VEC [8] = '{
    {3'd0, 18'h2A5A7, 18'h15A5B, 18'h2A5A4, 18'h15A58},
    {3'd1, 18'h3C0F1, 18'h0F0F3, 18'h3C0F1, 18'h0F0F3},
    {3'd2, 18'h12345, 18'h3FFFF, 18'h3FFFC, 18'h12344},
    {3'd3, 18'h00001, 18'h20000, 18'h20000, 18'h00001},
    {3'd4, 18'h1FFF3, 18'h2468B, 18'h24688, 18'h1FFF0},
    {3'd5, 18'h35555, 18'h0AAAA, 18'h0AAAA, 18'h35555},
    {3'd6, 18'h30003, 18'h0C00F, 18'h30000, 18'h0C00C},
    {3'd7, 18'h3FFFF, 18'h00000, 18'h3FFFC, 18'h00000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Bit at slot position i (32 bit clocks per slot); padding bits are 1 (R7)
  function automatic logic slot_bit(input logic [2:0] code, input logic [17:0] w, input int i);
    int n;
    int start;
    n = (code == 3'd1 || code == 3'd3 || code == 3'd5) ? 18 : 16;
    if (code == 3'd2 || code == 3'd3) start = 0;
    else if (code == 3'd4 || code == 3'd5) start = 32 - n;
    else start = 1;
    if (i >= start && i < start + n) return w[17 - (i - start)];
    return 1'b1;
  endfunction

  task automatic send_slot(input logic lr, input logic [2:0] code, input logic [17:0] w);
    for (int i = 0; i < 32; i++) begin
      bck = 1'b0; lrck = lr; din = slot_bit(code, w, i);
      tick(2);
      bck = 1'b1;
      tick(2);
    end
  endtask

  task automatic send_frame(input logic [2:0] code, input logic [17:0] a, input logic [17:0] b);
    fmt = code;
    send_slot(1'b0, code, a);
    send_slot(1'b1, code, b);
    bck = 1'b0; lrck = 1'b0; din = 1'b0;
    tick(4);
  endtask

  function automatic string tag_of(input logic [2:0] code);
    case (code)
      3'd0:    return "R2 R6";
      3'd1:    return "R2";
      3'd2:    return "R3 R6";
      3'd3:    return "R3";
      3'd4:    return "R4 R6";
      3'd5:    return "R4";
      default: return "R5 R6";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R11: reset state
    tick(5);
    chk("R11 valid", 18'(out_valid), 18'h0);
    chk("R11 left", out_left, 18'h0);
    chk("R11 right", out_right, 18'h0);
    rst_n = 1'b1;
    tick(2);

    // R1 R7 R8: one frame per vector, checked with ready low, then accepted
    for (int v = 0; v < 8; v++) begin
      send_frame(VEC[v][74:72], VEC[v][71:54], VEC[v][53:36]);
      chk({tag_of(VEC[v][74:72]), " R8 valid"}, 18'(out_valid), 18'h1);
      chk({tag_of(VEC[v][74:72]), " R1 R7 left"}, out_left, VEC[v][35:18]);
      chk({tag_of(VEC[v][74:72]), " R1 R7 right"}, out_right, VEC[v][17:0]);
      out_ready = 1'b1;
      tick(1);
      chk("R9 valid cleared", 18'(out_valid), 18'h0);
      out_ready = 1'b0;
    end

    // R9: pair holds while not accepted
    send_frame(VEC[0][74:72], VEC[0][71:54], VEC[0][53:36]);
    tick(20);
    chk("R9 hold valid", 18'(out_valid), 18'h1);
    chk("R9 hold left", out_left, VEC[0][35:18]);
    chk("R9 hold right", out_right, VEC[0][17:0]);

    // R10: next pair overwrites the unaccepted one
    send_frame(VEC[3][74:72], VEC[3][71:54], VEC[3][53:36]);
    chk("R10 valid", 18'(out_valid), 18'h1);
    chk("R10 left", out_left, VEC[3][35:18]);
    chk("R10 right", out_right, VEC[3][17:0]);
    out_ready = 1'b1;
    tick(1);
    chk("R9 final clear", 18'(out_valid), 18'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule